// File: doc/BRIEF.md
# Stereo Serial Sample Transmitter

This block takes one 24-bit left sample and one 24-bit right sample per frame and sends them one after the other on a single data line. It supports a left-justified framing and the standard I2S framing. A small holding stage with a valid/ready handshake accepts the parallel samples. When no new pair has arrived by the time a frame begins, the previous pair is sent again.

In master mode the block makes its own bit clock and frame clock from the core clock `clk`. The core clock runs at twice the master-clock rate, so one master-clock period lasts two `clk` cycles. A 2-bit speed code selects the dividers, and an optional pre-divide halves the master clock before any divider sees it. In slave mode an external source drives the bit clock and frame clock. The block brings both into the `clk` domain and times its output from the bit-clock falling edges it detects there. Each half-frame lasts as long as the external frame clock holds its level.

Top module: `audio_serial_tx`

## Requirements
- R1: Each channel word is 24-bit two's complement and is sent most significant bit first. Every frame carries one left word and one right word, and the left word comes first.
- R2: With `fmt_i2s`=0 (left-justified), the MSB occupies the first bit slot after a frame-clock transition, and the left word is sent while the frame clock is high.
- R3: With `fmt_i2s`=1 (I2S), the MSB occupies the second bit slot after a frame-clock transition, one slot later than in R2, and the left word is sent while the frame clock is low.
- R4: Every bit slot of a half-frame after the 24 word bits carries 0.
- R5: In master mode (`master_en`=1) the bit clock period is 8, 4 or 2 `clk` cycles for speed codes 00, 01 and 10 (master clock divided by 4, 2 or 1). The frame clock holds each level for 32 bit clocks, which gives 64 bit clocks per frame.
- R6: With `pre_div`=1 in master mode, every bit-clock and frame-clock period is twice its R5 value.
- R7: Speed code 11 is reserved. In master mode it keeps `bclk_out`, `lrclk_out` and `sdata` low.
- R8: In master mode, `sdata` and `lrclk_out` change only in the cycle where `bclk_out` falls.
- R9: A pair is accepted when `s_valid` and `s_ready` are both high. `s_ready` stays low while one accepted pair waits. The waiting pair is first sent in the next frame, which starts at the frame-clock transition into the left level.
- R10: If no pair is waiting at the start of a frame, the previous pair is sent again.
- R11: In slave mode (`master_en`=0), `bclk_in` and `lrclk_in` time the output, and the half-frame length follows `lrclk_in`. When a half-frame is shorter than the word, the low-order bits are dropped. `bclk_out` and `lrclk_out` stay low in this mode.
- R12: During and right after reset, `s_ready` is 1 and `bclk_out`, `lrclk_out` and `sdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| speed_mode | input | 2 | 00 single, 01 double, 10 quad, 11 reserved |
| pre_div | input | 1 | Halve the master clock before the dividers (master mode only) |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding stage empty |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| sdata | output | 1 | Serial data |

## Verification
The bench acts as a serial receiver. It samples on bit-clock rising edges, rebuilds each word and compares it against the pairs it pushed. If the design puts the MSB in the wrong slot for either format, the rebuilt words come back shifted by one bit. If it swaps the channel polarity, left and right come back exchanged. If it loads a new pair mid-frame, or fails to repeat the last pair, the second and third frames come back wrong. The bench also measures the bit-clock period under each divider and pre-divide setting, checks that padding slots are zero, and checks that data never changes outside a bit-clock fall. It drives a short external frame to confirm truncation in slave mode, and confirms that the reserved speed code keeps all outputs silent.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int WORD_W = 24;
    localparam int SLOT_W = 7;
    localparam int HCNT_W = 4;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    // Bit-clock half period in core clock cycles
    function automatic logic [HCNT_W-1:0] half_period(speed_e spd, logic pre);
        logic [HCNT_W-1:0] base;
        case (spd)
            SPD_SINGLE: base = HCNT_W'(4);
            SPD_DOUBLE: base = HCNT_W'(2);
            default:    base = HCNT_W'(1);
        endcase
        return pre ? HCNT_W'(base << 1) : base;
    endfunction
endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen
    import sap_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  speed_e speed,
    input  logic   pre_div,
    output logic   bclk,
    output logic   lrclk,
    output logic   fall_evt,
    output logic   lr_at_fall
);
    logic [HCNT_W-1:0] hcnt;
    logic [HCNT_W-1:0] hlim;
    logic [SW-1:0]     slot;
    logic [SW-1:0]     slot_nx;
    logic              run;
    logic              wrap;

    assign run        = en && (speed != SPD_RSVD);
    assign hlim       = half_period(speed, pre_div);
    assign wrap       = hcnt >= (hlim - HCNT_W'(1));
    assign slot_nx    = slot + SW'(1);
    assign fall_evt   = run && wrap && bclk;
    assign lr_at_fall = slot_nx[SW-1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt  <= '0;
            bclk  <= 1'b0;
            lrclk <= 1'b0;
            slot  <= '0;
        end else if (wrap) begin
            hcnt <= '0;
            bclk <= ~bclk;
            if (bclk) begin
                slot  <= slot_nx;
                lrclk <= lr_at_fall;
            end
        end else begin
            hcnt <= hcnt + HCNT_W'(1);
        end
    end

    // R8
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (rst || !run)
        !$stable(lrclk) |-> $fell(bclk));
    // R7
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && speed == SPD_RSVD) |=> (!bclk && !lrclk));
endmodule

// File: rtl/sap_slave_sync.sv
module sap_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_pin,
    input  logic lrclk_pin,
    output logic fall_evt,
    output logic lr_level
);
    logic [STAGES-1:0] b_sh;
    logic [STAGES-1:0] l_sh;
    logic              b_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_sh   <= '0;
            l_sh   <= '0;
            b_last <= 1'b0;
        end else begin
            b_sh   <= {b_sh[STAGES-2:0], bclk_pin};
            l_sh   <= {l_sh[STAGES-2:0], lrclk_pin};
            b_last <= b_sh[STAGES-1];
        end
    end

    assign fall_evt = b_last && !b_sh[STAGES-1];
    assign lr_level = l_sh[STAGES-1];
endmodule

// File: rtl/sap_serializer.sv
module sap_serializer
    import sap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  lr_level,
    input  logic  i2s,
    input  logic  s_valid,
    input  pair_t s_pair,
    output logic  s_ready,
    output logic  sdata
);
    pair_t             cur;
    pair_t             pend;
    pair_t             use_pair;
    logic              pend_full;
    logic              lr_prev;
    logic [SLOT_W-1:0] idx;
    logic [SLOT_W-1:0] idx_nx;
    logic [SLOT_W-1:0] k;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shifted;
    logic              edge_seen, left_half, frame_start, take, accept, bit_nx;

    assign s_ready     = !pend_full;
    assign accept      = s_valid && !pend_full;
    assign edge_seen   = tick && (lr_level != lr_prev);
    assign left_half   = i2s ? !lr_level : lr_level;
    assign frame_start = edge_seen && left_half;
    assign take        = frame_start && pend_full;
    assign use_pair    = take ? pend : cur;

    always_comb begin
        if (edge_seen)        idx_nx = '0;
        else if (&idx)        idx_nx = idx;
        else                  idx_nx = idx + SLOT_W'(1);
        k       = idx_nx - SLOT_W'(i2s);
        word    = left_half ? use_pair.left : use_pair.right;
        shifted = word << k;
        bit_nx  = (k < SLOT_W'(WORD_W)) ? shifted[WORD_W-1] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            pend      <= '0;
            pend_full <= 1'b0;
            lr_prev   <= 1'b0;
            idx       <= '1;
            sdata     <= 1'b0;
        end else begin
            if (accept) begin
                pend      <= s_pair;
                pend_full <= 1'b1;
            end else if (take) begin
                pend_full <= 1'b0;
            end
            if (tick) begin
                cur     <= use_pair;
                lr_prev <= lr_level;
                idx     <= idx_nx;
                sdata   <= bit_nx;
            end
        end
    end

    // R8
    sdata_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> $past(tick));
    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && idx_nx >= SLOT_W'(WORD_W + 1)) |=> !sdata);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_ready && !take) |=> ($stable(pend) && !s_ready));
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import sap_pkg::*;
#(
    parameter int FRAME_SLOTS = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic [1:0]        speed_mode,
    input  logic              pre_div,
    input  logic              fmt_i2s,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_left,
    input  logic [WORD_W-1:0] s_right,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              bclk_out,
    output logic              lrclk_out,
    output logic              sdata
);
    logic  m_fall, m_lr, s_fall, s_lr;
    logic  tick, lr_level;
    pair_t in_pair;

    assign in_pair = '{left: s_left, right: s_right};

    sap_clkgen #(.SLOTS(FRAME_SLOTS)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .en         (master_en),
        .speed      (speed_e'(speed_mode)),
        .pre_div    (pre_div),
        .bclk       (bclk_out),
        .lrclk      (lrclk_out),
        .fall_evt   (m_fall),
        .lr_at_fall (m_lr)
    );

    sap_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .bclk_pin  (bclk_in),
        .lrclk_pin (lrclk_in),
        .fall_evt  (s_fall),
        .lr_level  (s_lr)
    );

    assign tick     = master_en ? m_fall : s_fall;
    assign lr_level = master_en ? m_lr   : s_lr;

    sap_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .lr_level (lr_level),
        .i2s      (fmt_i2s),
        .s_valid  (s_valid),
        .s_pair   (in_pair),
        .s_ready  (s_ready),
        .sdata    (sdata)
    );

    // R11
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> (!bclk_out && !lrclk_out));
endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1, master_en = 1'b1, pre_div = 1'b0, fmt_i2s = 1'b0;
    logic        s_valid = 1'b0, bclk_in = 1'b0, lrclk_in = 1'b0;
    logic [1:0]  speed_mode = 2'b00;
    logic [23:0] s_left = '0, s_right = '0;
    logic        s_ready, bclk_out, lrclk_out, sdata;

    audio_serial_tx u_dut (
        .clk(clk), .rst(rst), .master_en(master_en), .speed_mode(speed_mode),
        .pre_div(pre_div), .fmt_i2s(fmt_i2s), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdata(sdata)
    );

    localparam int NV = 7;
    localparam logic [1:0]  T_SPD [NV] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01};
    localparam logic        T_PRE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic        T_I2S [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [23:0] T_AL  [NV] = '{24'hC3A5F1, 24'h800001, 24'h123456, 24'hFEDCBA,
                                           24'hA00005, 24'h5A5A5A, 24'h800000};
    localparam logic [23:0] T_AR  [NV] = '{24'h0F0E0D, 24'h7FFFFE, 24'hABCDEF, 24'h000001,
                                           24'h3C3C3C, 24'hE1E1E1, 24'h7FFFFF};
    localparam logic [23:0] T_BL  [NV] = '{24'h7FFFFF, 24'h00F00F, 24'h999999, 24'h400002,
                                           24'h0000FF, 24'hFFFF00, 24'h010203};
    localparam logic [23:0] T_BR  [NV] = '{24'h800000, 24'hF00F00, 24'h666666, 24'h200004,
                                           24'hFF0000, 24'h00FFFF, 24'hFCFDFE};

    int n_chk = 0, n_bad = 0, cyc = 0;
    localparam int WD_LIMIT = 190000;

    // receiver state
    int          exp_per = 8, exp_half = 32, off = 0;
    int          rx_n, rx_idx, last_rise, pad_err, len_err, per_err, edge_err;
    logic [23:0] rx_l [8];
    logic [23:0] rx_r [8];
    logic [23:0] rx_word, held_l;
    logic        seen, started, rx_lr, have_l, have_rise;
    logic        b_prev, l_prev, sd_prev, ob_prev;

    task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task finish_half();
        logic is_left;
        if (rx_idx + 1 != exp_half) len_err++;
        is_left = off != 0 ? !rx_lr : rx_lr;
        if (is_left) begin
            held_l = rx_word;
            have_l = 1'b1;
        end else if (have_l) begin
            if (rx_n < 8) begin
                rx_l[rx_n] = held_l;
                rx_r[rx_n] = rx_word;
            end
            rx_n++;
            have_l = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        logic ob, lo;
        int   p;
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        ob = master_en ? bclk_out : bclk_in;
        lo = master_en ? lrclk_out : lrclk_in;
        if (rst) begin
            rx_n = 0; rx_idx = 0; last_rise = 0; pad_err = 0; len_err = 0;
            per_err = 0; edge_err = 0; rx_word = '0; held_l = '0;
            seen = 0; started = 0; rx_lr = 0; have_l = 0; have_rise = 0;
        end else begin
            if (master_en) begin
                if (sdata !== sd_prev && !(b_prev && !bclk_out)) edge_err++;
                if (lrclk_out !== l_prev && !(b_prev && !bclk_out)) edge_err++;
            end
            if (ob && !ob_prev) begin
                if (master_en && have_rise && (cyc - last_rise) != exp_per) per_err++;
                have_rise = 1;
                last_rise = cyc;
                if (seen && lo != rx_lr) begin
                    if (started) finish_half();
                    started = 1;
                    rx_idx  = 0;
                    rx_word = '0;
                end else begin
                    rx_idx++;
                end
                seen  = 1;
                rx_lr = lo;
                if (started) begin
                    p = rx_idx - off;
                    if (p >= 0 && p < 24) rx_word = {rx_word[22:0], sdata};
                    else if (sdata) pad_err++;
                end
            end
        end
        b_prev = bclk_out; l_prev = lrclk_out; sd_prev = sdata; ob_prev = ob;
    end

    task automatic do_reset(input logic m, input logic [1:0] spd, input logic pre, input logic i2s);
        @(negedge clk);
        rst = 1; master_en = m; speed_mode = spd; pre_div = pre; fmt_i2s = i2s;
        s_valid = 0; bclk_in = 0; lrclk_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r);
        logic rdy;
        @(negedge clk);
        s_valid = 1; s_left = l; s_right = r;
        do begin
            rdy = s_ready;
            @(negedge clk);
        end while (!rdy);
        s_valid = 0;
    endtask

    task automatic wait_frames(input int n);
        for (int w = 0; w < 20000 && rx_n < n; w++) @(negedge clk);
    endtask

    function automatic int div_of(input logic [1:0] spd);
        return spd == 2'b00 ? 4 : (spd == 2'b01 ? 2 : 1);
    endfunction

    task automatic run_master(input int v);
        string fr, pr;
        fr = T_I2S[v] ? "R3" : "R2";
        pr = T_PRE[v] ? "R6" : "R5";
        exp_per  = 2 * div_of(T_SPD[v]) * (T_PRE[v] ? 2 : 1);
        exp_half = 32;
        off      = T_I2S[v] ? 1 : 0;
        do_reset(1'b1, T_SPD[v], T_PRE[v], T_I2S[v]);
        push(T_AL[v], T_AR[v]);
        check("R9", "ready low while pair waits", s_ready, 0);
        push(T_BL[v], T_BR[v]);
        wait_frames(3);
        check("R1", "frames received", rx_n >= 3, 1);
        check(fr, "frame0 left", rx_l[0], T_AL[v]);
        check("R1", "frame0 right", rx_r[0], T_AR[v]);
        check("R9", "frame1 left", rx_l[1], T_BL[v]);
        check("R9", "frame1 right", rx_r[1], T_BR[v]);
        check("R10", "frame2 left repeat", rx_l[2], T_BL[v]);
        check("R10", "frame2 right repeat", rx_r[2], T_BR[v]);
        check("R4", "nonzero padding bits", pad_err, 0);
        check("R5", "half-frame length errors", len_err, 0);
        check(pr, "bit clock period errors", per_err, 0);
        check("R8", "changes off bit-clock fall", edge_err, 0);
    endtask

    task automatic run_slave(input int ratio);
        logic [23:0] al, ar, bl, br;
        int sh;
        al = 24'h9A8B7C; ar = 24'h13579B; bl = 24'h2468AC; br = 24'hF0F0F0;
        sh = ratio == 32 ? 8 : 0;
        exp_half = ratio / 2;
        off = 0;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0);
        fork
            begin
                push(al, ar);
                push(bl, br);
            end
            begin
                for (int s = 0; s < 5 * ratio; s++) begin
                    @(negedge clk);
                    bclk_in  = 0;
                    lrclk_in = (s % ratio) >= (ratio / 2);
                    repeat (7) @(negedge clk);
                    bclk_in = 1;
                    check("R11", "generated clocks idle in slave", {bclk_out, lrclk_out}, 0);
                    repeat (8) @(negedge clk);
                end
                bclk_in = 0;
            end
        join
        check("R11", "slave frames received", rx_n >= 3, 1);
        check("R11", "slave frame0 left", rx_l[0], al >> sh);
        check("R11", "slave frame0 right", rx_r[0], ar >> sh);
        check("R11", "slave frame1 left", rx_l[1], bl >> sh);
        check("R10", "slave frame2 right repeat", rx_r[2], br >> sh);
        check("R11", "slave half-frame length errors", len_err, 0);
        check("R4", "slave nonzero padding bits", pad_err, 0);
    endtask

    initial begin
        int hi_b, hi_l, hi_d;
        // reset state
        repeat (3) @(negedge clk);
        check("R12", "s_ready in reset", s_ready, 1);
        check("R12", "outputs in reset", {bclk_out, lrclk_out, sdata}, 0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12", "s_ready after reset", s_ready, 1);
        check("R12", "sdata after reset", sdata, 0);

        for (int v = 0; v < NV; v++) run_master(v);

        // reserved speed code
        do_reset(1'b1, 2'b11, 1'b0, 1'b0);
        push(24'hFFFFFF, 24'hFFFFFF);
        hi_b = 0; hi_l = 0; hi_d = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (bclk_out) hi_b++;
            if (lrclk_out) hi_l++;
            if (sdata) hi_d++;
        end
        check("R7", "bit clock activity", hi_b, 0);
        check("R7", "frame clock activity", hi_l, 0);
        check("R7", "data activity", hi_d, 0);

        run_slave(64);
        run_slave(32);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule